// File: doc/BRIEF.md
# Interrupt Dispatch Sequencer

This block sits beside a small 8-bit CPU core and decides when the core stops fetching instructions in order to service an interrupt. Peripheral request pulses collect in a pending register. A separate mask register selects which sources may interrupt. A three-state master enable, driven by the core's enable and disable commands, gates the whole mechanism.

When the core signals that it is at an instruction boundary, the master enable is fully on, and some source is both pending and unmasked, the block takes over for five clock cycles. During that time it blocks fetch, writes the current program counter to the stack one byte per cycle, and loads a new program counter. The source with the lowest index wins. In the third cycle the block samples the winner's mask bit again. If software has masked that source in the meantime, the dispatch ends at address 0x0000 and the pending bit is kept.

The block also tells a halted core to wake whenever an arriving request meets an unmasked source. This wake does not depend on the master enable.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, `fetch_allow` is 1, both registers read 0x00, the master enable is off, and no dispatch starts until an enable command has been given.
- R2: Both registers store and return all 8 written bits. Only bits 4:0 of the pending register act as requests, so pending bits 7:5 never start a dispatch.
- R3: When several sources are pending and unmasked, the lowest bit index is serviced. Bit 0 has the highest priority.
- R4: A dispatch starts at a clock edge only if all of these hold in that cycle: `at_fetch`=1, the master enable is on, and (pending & mask)[4:0] is non-zero. Otherwise `fetch_allow` stays 1.
- R5: Starting a dispatch turns the master enable off. `fetch_allow` is 0 for the five dispatch cycles. A later boundary strobe without a new enable command does not dispatch.
- R6: In dispatch cycle 3, `stk_we`=1, `stk_addr`=SP-1 and `stk_wdata`=PC[15:8]. In cycle 4, `stk_we`=1, `stk_addr`=SP-2 and `stk_wdata`=PC[7:0]. Also in cycle 4, `sp_ld`=1 with `sp_nxt`=SP-2.
- R7: In cycle 5 of a dispatch that was not cancelled, `pc_ld`=1 with `pc_nxt`=0x40+8*index. The serviced pending bit is then clear.
- R8: The winner's mask bit is sampled during cycle 3. If it is 0, cycle 5 loads 0x0000 and the pending register is left unchanged. A mask write made during cycle 3 itself does not cancel.
- R9: An enable command arms the master enable. The next cycle turns it on, so a boundary strobe in the cycle right after the command does not dispatch, but one in the cycle after that does. A disable command turns the master enable off at once and wins over a simultaneous enable command.
- R10: Request pulses OR into pending bits 4:0 and win over a register write to those bits in the same cycle. `halt_wake` is 1 in a cycle where `irq_req` is non-zero and ((pending | irq_req) & mask)[4:0] is non-zero, whatever the state of the master enable.
- R11: `fetch_allow` returns to 1 in the cycle after cycle 5.
- R12: A request for the serviced source that arrives in cycle 5 leaves its pending bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 5 | Request pulses, one bit per source |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 pending, 1 mask |
| reg_wdata | input | 8 | Register write data |
| flag_rdata | output | 8 | Pending register contents |
| mask_rdata | output | 8 | Mask register contents |
| at_fetch | input | 1 | Core is at an instruction fetch boundary |
| ei_cmd | input | 1 | Master enable command |
| di_cmd | input | 1 | Master disable command |
| pc_cur | input | 16 | Current program counter |
| sp_cur | input | 16 | Current stack pointer |
| fetch_allow | output | 1 | Core may fetch |
| stk_we | output | 1 | Stack byte write |
| stk_addr | output | 16 | Stack write address |
| stk_wdata | output | 8 | Stack write byte |
| sp_ld | output | 1 | Load stack pointer |
| sp_nxt | output | 16 | New stack pointer |
| pc_ld | output | 1 | Load program counter |
| pc_nxt | output | 16 | New program counter |
| halt_wake | output | 1 | Release the core from halt |

## Verification
Two functions can fall in the same cycle and must both take effect correctly. The first pair is the pending-bit clear of cycle 5 and a fresh request for the same source: the bench raises that source's request pulse in cycle 5 and expects the bit to read back as still set. The second pair is the cycle-3 mask sample and a mask write. The bench writes the mask either in cycle 2 or in cycle 3, and it expects a 0x0000 load with the pending register unchanged only in the first case. Random pending and mask patterns, together with random choices among these overlaps, are compared against a bench model of priority, vectors and push addresses.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int SRC_N      = 5;
    localparam int IDX_W      = $clog2(SRC_N);
    localparam int REG_W      = 8;
    localparam int ADDR_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int STEP_W     = 3;
    localparam int STEP_FIRST = 1;
    localparam int STEP_HI    = 3;
    localparam int STEP_LO    = 4;
    localparam int STEP_LAST  = 5;
    localparam int VEC_STRIDE = 8;
    localparam logic [ADDR_W-1:0] VEC_BASE   = 16'h0040;
    localparam logic [ADDR_W-1:0] VEC_ABORT  = 16'h0000;

    typedef enum logic [1:0] {
        ME_OFF   = 2'd0,
        ME_ARMED = 2'd1,
        ME_ON    = 2'd2
    } mstr_e;

    typedef struct packed {
        logic              active;
        logic [STEP_W-1:0] step;
        logic [IDX_W-1:0]  src;
        logic              abort;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] sp;
    } disp_s;

    // lowest set index wins
    function automatic logic [IDX_W-1:0] first_set(input logic [SRC_N-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] vec_addr(input logic [IDX_W-1:0] s);
        return VEC_BASE + (ADDR_W'(s) * ADDR_W'(VEC_STRIDE));
    endfunction

endpackage

// File: rtl/irqd_regs.sv
module irqd_regs
    import irqd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_N-1:0]  req,
    input  logic              we,
    input  logic              sel,
    input  logic [REG_W-1:0]  wdata,
    input  logic              clr,
    input  logic [IDX_W-1:0]  clr_src,
    output logic [REG_W-1:0]  flag_q,
    output logic [REG_W-1:0]  mask_q
);

    logic flag_we;
    logic mask_we;

    assign flag_we = we && !sel;
    assign mask_we = we && sel;

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_we) mask_q <= wdata;
    end

    for (genvar b = 0; b < REG_W; b++) begin : g_flag
        if (b < SRC_N) begin : g_src
            // write, then clear on service, then new request on top
            logic nxt;
            always_comb begin
                nxt = flag_we ? wdata[b] : flag_q[b];
                if (clr && (clr_src == IDX_W'(b))) nxt = 1'b0;
                if (req[b]) nxt = 1'b1;
            end
            always_ff @(posedge clk) begin
                if (rst) flag_q[b] <= 1'b0;
                else     flag_q[b] <= nxt;
            end
        end else begin : g_spare
            always_ff @(posedge clk) begin
                if (rst)          flag_q[b] <= 1'b0;
                else if (flag_we) flag_q[b] <= wdata[b];
            end
        end
    end

endmodule

// File: rtl/irqd_master.sv
module irqd_master
    import irqd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ei,
    input  logic  di,
    input  logic  take,
    output logic  is_on
);

    mstr_e st_q;
    mstr_e st_d;

    always_comb begin
        st_d = st_q;
        if (take || di)                  st_d = ME_OFF;
        else if (st_q == ME_ARMED)       st_d = ME_ON;
        else if (ei && st_q == ME_OFF)   st_d = ME_ARMED;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ME_OFF;
        else     st_q <= st_d;
    end

    assign is_on = (st_q == ME_ON);

endmodule

// File: rtl/irqd_seq.sv
module irqd_seq
    import irqd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_src,
    input  logic [ADDR_W-1:0] pc_cur,
    input  logic [ADDR_W-1:0] sp_cur,
    input  logic [SRC_N-1:0]  mask,
    output logic              busy,
    output logic              stk_we,
    output logic [ADDR_W-1:0] stk_addr,
    output logic [BYTE_W-1:0] stk_wdata,
    output logic              sp_ld,
    output logic [ADDR_W-1:0] sp_nxt,
    output logic              pc_ld,
    output logic [ADDR_W-1:0] pc_nxt,
    output logic              clr,
    output logic [IDX_W-1:0]  clr_src
);

    disp_s d_q;
    logic  at_hi;
    logic  at_lo;
    logic  at_end;

    assign at_hi  = d_q.active && (d_q.step == STEP_W'(STEP_HI));
    assign at_lo  = d_q.active && (d_q.step == STEP_W'(STEP_LO));
    assign at_end = d_q.active && (d_q.step == STEP_W'(STEP_LAST));

    always_ff @(posedge clk) begin
        if (rst) begin
            d_q <= '0;
        end else if (start && !d_q.active) begin
            d_q.active <= 1'b1;
            d_q.step   <= STEP_W'(STEP_FIRST);
            d_q.src    <= start_src;
            d_q.abort  <= 1'b0;
            d_q.pc     <= pc_cur;
            d_q.sp     <= sp_cur;
        end else if (d_q.active) begin
            if (at_hi) d_q.abort <= !mask[d_q.src];
            if (at_end) begin
                d_q.active <= 1'b0;
                d_q.step   <= '0;
            end else begin
                d_q.step   <= d_q.step + STEP_W'(1);
            end
        end
    end

    assign busy      = d_q.active;
    assign stk_we    = at_hi || at_lo;
    assign stk_addr  = at_lo ? (d_q.sp - ADDR_W'(2)) : (d_q.sp - ADDR_W'(1));
    assign stk_wdata = at_lo ? d_q.pc[BYTE_W-1:0] : d_q.pc[ADDR_W-1:BYTE_W];
    assign sp_ld     = at_lo;
    assign sp_nxt    = d_q.sp - ADDR_W'(2);
    assign pc_ld     = at_end;
    assign pc_nxt    = d_q.abort ? VEC_ABORT : vec_addr(d_q.src);
    assign clr       = at_end && !d_q.abort;
    assign clr_src   = d_q.src;

endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
    import irqd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_N-1:0]  irq_req,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  flag_rdata,
    output logic [REG_W-1:0]  mask_rdata,
    input  logic              at_fetch,
    input  logic              ei_cmd,
    input  logic              di_cmd,
    input  logic [ADDR_W-1:0] pc_cur,
    input  logic [ADDR_W-1:0] sp_cur,
    output logic              fetch_allow,
    output logic              stk_we,
    output logic [ADDR_W-1:0] stk_addr,
    output logic [BYTE_W-1:0] stk_wdata,
    output logic              sp_ld,
    output logic [ADDR_W-1:0] sp_nxt,
    output logic              pc_ld,
    output logic [ADDR_W-1:0] pc_nxt,
    output logic              halt_wake
);

    logic [REG_W-1:0] flag_q;
    logic [REG_W-1:0] mask_q;
    logic [SRC_N-1:0] live;
    logic             me_on;
    logic             seq_busy;
    logic             take;
    logic             clr;
    logic [IDX_W-1:0] clr_src;

    assign live = flag_q[SRC_N-1:0] & mask_q[SRC_N-1:0];
    assign take = at_fetch && me_on && (|live) && !seq_busy;

    irqd_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (irq_req),
        .we      (reg_we),
        .sel     (reg_sel),
        .wdata   (reg_wdata),
        .clr     (clr),
        .clr_src (clr_src),
        .flag_q  (flag_q),
        .mask_q  (mask_q)
    );

    irqd_master u_master (
        .clk   (clk),
        .rst   (rst),
        .ei    (ei_cmd),
        .di    (di_cmd),
        .take  (take),
        .is_on (me_on)
    );

    irqd_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (take),
        .start_src (first_set(live)),
        .pc_cur    (pc_cur),
        .sp_cur    (sp_cur),
        .mask      (mask_q[SRC_N-1:0]),
        .busy      (seq_busy),
        .stk_we    (stk_we),
        .stk_addr  (stk_addr),
        .stk_wdata (stk_wdata),
        .sp_ld     (sp_ld),
        .sp_nxt    (sp_nxt),
        .pc_ld     (pc_ld),
        .pc_nxt    (pc_nxt),
        .clr       (clr),
        .clr_src   (clr_src)
    );

    assign flag_rdata  = flag_q;
    assign mask_rdata  = mask_q;
    assign fetch_allow = !seq_busy;
    assign halt_wake   = (|irq_req) &&
                         (|((flag_q[SRC_N-1:0] | irq_req) & mask_q[SRC_N-1:0]));

endmodule

// File: rtl/irqd_chk.sv
module irqd_chk
    import irqd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [SRC_N-1:0]  irq_req,
    input logic              fetch_allow,
    input logic              stk_we,
    input logic [ADDR_W-1:0] stk_addr,
    input logic              sp_ld,
    input logic [ADDR_W-1:0] sp_nxt,
    input logic              pc_ld,
    input logic [ADDR_W-1:0] pc_nxt,
    input logic              halt_wake
);

    // R1
    reset_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> fetch_allow);

    // R6
    push_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (stk_we && !$past(stk_we)) |=> (stk_we && stk_addr == $past(stk_addr) - 16'd1));

    // R6
    sp_update_chk: assert property (@(posedge clk) disable iff (rst)
        sp_ld |-> (stk_we && sp_nxt == stk_addr));

    // R7
    load_after_push_chk: assert property (@(posedge clk) disable iff (rst)
        (stk_we && $past(stk_we)) |=> pc_ld);

    // R5
    fetch_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_ld || stk_we) |-> !fetch_allow);

    // R11
    fetch_resume_chk: assert property (@(posedge clk) disable iff (rst)
        pc_ld |=> fetch_allow);

    // R7
    vector_range_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_ld && pc_nxt != 16'h0000) |->
            (pc_nxt[2:0] == 3'b000 && pc_nxt >= 16'h0040 && pc_nxt <= 16'h0060));

    // R10
    wake_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        halt_wake |-> (irq_req != '0));

endmodule

bind irq_dispatch irqd_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_req     (irq_req),
    .fetch_allow (fetch_allow),
    .stk_we      (stk_we),
    .stk_addr    (stk_addr),
    .sp_ld       (sp_ld),
    .sp_nxt      (sp_nxt),
    .pc_ld       (pc_ld),
    .pc_nxt      (pc_nxt),
    .halt_wake   (halt_wake)
);

// File: tb/tb_irq_dispatch.sv
module tb_irq_dispatch;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  irq_req;
    logic        reg_we, reg_sel;
    logic [7:0]  reg_wdata;
    logic [7:0]  flag_rdata, mask_rdata;
    logic        at_fetch, ei_cmd, di_cmd;
    logic [15:0] pc_cur, sp_cur;
    logic        fetch_allow, stk_we, sp_ld, pc_ld, halt_wake;
    logic [15:0] stk_addr, sp_nxt, pc_nxt;
    logic [7:0]  stk_wdata;

    int checks = 0;
    int errors = 0;
    int ncyc   = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    irq_dispatch dut (
        .clk(clk), .rst(rst), .irq_req(irq_req),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .flag_rdata(flag_rdata), .mask_rdata(mask_rdata),
        .at_fetch(at_fetch), .ei_cmd(ei_cmd), .di_cmd(di_cmd),
        .pc_cur(pc_cur), .sp_cur(sp_cur),
        .fetch_allow(fetch_allow), .stk_we(stk_we), .stk_addr(stk_addr),
        .stk_wdata(stk_wdata), .sp_ld(sp_ld), .sp_nxt(sp_nxt),
        .pc_ld(pc_ld), .pc_nxt(pc_nxt), .halt_wake(halt_wake)
    );

    function automatic int lowest(input logic [4:0] v);
        for (int i = 0; i < 5; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [15:0] vec_of(input int i);
        return 16'h0040 + 16'(i * 8);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        cyc();
        reg_we = 1'b0;
    endtask

    // mode: 0 plain, 1 mask cleared in cycle 2 (cancel),
    //       2 mask cleared in cycle 3 (no cancel), 3 request in cycle 5
    task automatic run_case(input logic [7:0] f, input logic [7:0] m,
                            input logic [15:0] pc, input logic [15:0] sp, input int mode);
        int          idx;
        logic [4:0]  live;
        logic [7:0]  fexp;
        bit          abort;
        pc_cur = pc; sp_cur = sp;
        wr(1'b0, f);
        wr(1'b1, m);
        ei_cmd = 1'b1;
        cyc();
        ei_cmd = 1'b0;
        at_fetch = 1'b1;
        cyc();
        check("R9 no dispatch one cycle after enable", {31'd0, fetch_allow}, 32'd1);
        cyc();
        at_fetch = 1'b0;
        live = f[4:0] & m[4:0];
        if (live == 5'd0) begin
            check("R4/R2 no dispatch without live source", {31'd0, fetch_allow}, 32'd1);
            di_cmd = 1'b1; cyc(); di_cmd = 1'b0;
            return;
        end
        idx   = lowest(live);
        abort = (mode == 1);
        check("R5 fetch blocked cycle 1", {31'd0, fetch_allow}, 32'd0);
        cyc();
        check("R6 no push cycle 2", {31'd0, stk_we}, 32'd0);
        if (mode == 1) begin reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = m & ~(8'd1 << idx); end
        cyc();
        reg_we = 1'b0;
        check("R6 high push we", {31'd0, stk_we}, 32'd1);
        check("R6 high push addr", {16'd0, stk_addr}, {16'd0, 16'(sp - 16'd1)});
        check("R6 high push data", {24'd0, stk_wdata}, {24'd0, pc[15:8]});
        if (mode == 2) begin reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = m & ~(8'd1 << idx); end
        cyc();
        reg_we = 1'b0;
        check("R6 low push addr", {15'd0, stk_we, stk_addr}, {15'd0, 1'b1, 16'(sp - 16'd2)});
        check("R6 low push data", {24'd0, stk_wdata}, {24'd0, pc[7:0]});
        check("R6 sp load", {15'd0, sp_ld, sp_nxt}, {15'd0, 1'b1, 16'(sp - 16'd2)});
        cyc();
        check(abort ? "R8 cancelled vector" : "R3/R7 vector",
              {15'd0, pc_ld, pc_nxt}, {15'd0, 1'b1, abort ? 16'h0000 : vec_of(idx)});
        if (mode == 3) irq_req = 5'(1 << idx);
        cyc();
        irq_req = 5'd0;
        check("R11 fetch resumes", {31'd0, fetch_allow}, 32'd1);
        if (abort)          fexp = f;
        else if (mode == 3) fexp = f;
        else                fexp = f & ~(8'd1 << idx);
        check(abort ? "R8 flags kept" : (mode == 3 ? "R12 request kept" : "R7 flag cleared"),
              {24'd0, flag_rdata}, {24'd0, fexp});
        at_fetch = 1'b1;
        cyc();
        at_fetch = 1'b0;
        check("R5 master off after dispatch", {31'd0, fetch_allow}, 32'd1);
    endtask

    always @(posedge clk) begin
        ncyc++;
        if (ncyc > 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", ncyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] f, m;
        rst = 1'b1; irq_req = '0; reg_we = 0; reg_sel = 0; reg_wdata = '0;
        at_fetch = 0; ei_cmd = 0; di_cmd = 0; pc_cur = 16'h1234; sp_cur = 16'hFFFE;
        void'($urandom(32'd2024));
        cyc(); cyc(); cyc();
        rst = 1'b0;
        cyc();
        // R1
        check("R1 fetch after reset", {31'd0, fetch_allow}, 32'd1);
        check("R1 flags after reset", {24'd0, flag_rdata}, 32'd0);
        check("R1 mask after reset", {24'd0, mask_rdata}, 32'd0);
        wr(1'b0, 8'h01); wr(1'b1, 8'h01);
        at_fetch = 1'b1; cyc(); cyc(); at_fetch = 1'b0;
        check("R1 no dispatch before enable", {31'd0, fetch_allow}, 32'd1);

        // R2 upper pending bits are stored but inert
        run_case(8'hE0, 8'hFF, 16'h0100, 16'hC000, 0);
        check("R2 upper bits read back", {24'd0, flag_rdata}, 32'h000000E0);

        // R3 priority, R4 pending without mask
        run_case(8'h1F, 8'h18, 16'hABCD, 16'hD000, 0);
        run_case(8'h04, 8'h03, 16'h0200, 16'hD000, 0);
        run_case(8'h11, 8'hFF, 16'h8001, 16'h0001, 0);

        // R8 cancel boundary, R12 request during clear
        run_case(8'h06, 8'h06, 16'h4455, 16'hE000, 1);
        run_case(8'h06, 8'h06, 16'h4455, 16'hE000, 2);
        run_case(8'h08, 8'h08, 16'h7788, 16'hE000, 3);

        // R9 disable right after enable, and together with enable
        wr(1'b0, 8'h01); wr(1'b1, 8'h01);
        ei_cmd = 1'b1; cyc(); ei_cmd = 1'b0;
        di_cmd = 1'b1; cyc(); di_cmd = 1'b0;
        at_fetch = 1'b1; cyc(); cyc(); at_fetch = 1'b0;
        check("R9 disable cancels armed enable", {31'd0, fetch_allow}, 32'd1);
        ei_cmd = 1'b1; di_cmd = 1'b1; cyc(); ei_cmd = 1'b0; di_cmd = 1'b0;
        cyc();
        at_fetch = 1'b1; cyc(); cyc(); at_fetch = 1'b0;
        check("R9 disable wins over enable", {31'd0, fetch_allow}, 32'd1);

        // R10 wake and request merge, master enable off
        wr(1'b0, 8'h00); wr(1'b1, 8'h04);
        irq_req = 5'h02; #1;
        check("R10 masked request no wake", {31'd0, halt_wake}, 32'd0);
        irq_req = 5'h04; #1;
        check("R10 unmasked request wakes", {31'd0, halt_wake}, 32'd1);
        irq_req = 5'h00; #1;
        check("R10 no wake without request", {31'd0, halt_wake}, 32'd0);
        reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h80; irq_req = 5'h01;
        cyc();
        reg_we = 1'b0; irq_req = 5'h00;
        check("R10 request beats write", {24'd0, flag_rdata}, 32'h00000081);
        irq_req = 5'h02; #1;
        check("R10 wake needs unmasked source", {31'd0, halt_wake}, 32'd0);
        cyc(); irq_req = 5'h00;
        wr(1'b0, 8'h04);
        irq_req = 5'h02; #1;
        check("R10 pending unmasked plus request wakes", {31'd0, halt_wake}, 32'd1);
        cyc(); irq_req = 5'h00;

        // random mix
        for (int k = 0; k < 60; k++) begin
            f = 8'($urandom);
            m = 8'($urandom);
            if ($urandom_range(0, 3) != 0) begin
                f[$urandom_range(0, 4)] = 1'b1;
                m = m | f;
            end
            run_case(f, m, 16'($urandom), 16'($urandom), int'($urandom_range(0, 3)));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule